// File: doc/BRIEF.md
# Dual Microsecond Timebase Counter

This block keeps two independent time counters for a wireless MAC subsystem. The first is a system time in microseconds, clocked by the register-bus clock. It only ever moves forward and is cleared by nothing except the bus-domain reset. A programmable prescaler divides the bus clock so that the count advances once per microsecond.

The second is a MAC time, clocked by a separate processing clock. It is built from two parts. A fractional part counts processing-clock cycles up to a programmed limit and then wraps. An integer part advances each time the fractional part wraps. Software can load a new integer value at any moment, including one smaller than the current value. The live integer and fractional values are driven out continuously, so that transmit and receive logic elsewhere can latch a timestamp on its own capture strobe.

Configuration reaches the processing domain through toggle-handshake synchronizers. A 64-bit read of the system time is made consistent by latching the upper word at the moment the lower word is read.

Top module: `tbase_top`

## Requirements
- R1: The system time only ever holds its value or advances by exactly one between bus-clock cycles. Only the bus reset clears it.
- R2: The system time advances once every N bus cycles, where N is the value in register 0 (sys divider). A divider of 0 acts as 1.
- R3: While the fractional MAC time is below limit-1, it increases by one on each processing-clock cycle and the integer MAC time holds. The limit is the value in register 1 (MAC divider).
- R4: When the fractional MAC time reaches limit-1 or more, it returns to 0 and the integer MAC time increases by one. The integer part therefore advances once every limit cycles.
- R5: A MAC divider of 0 acts as 1. The fractional part stays at 0 and the integer part advances on every processing-clock cycle.
- R6: Writing register 2 stages the lower 32 bits of a load value. Writing register 3 supplies the upper 32 bits and triggers the load. The load sets the integer MAC time to {reg3, reg2} and the fractional part to 0, exactly once, even when the new value is smaller than the current one.
- R7: Writes to registers 4 and 5 have no effect on the system time.
- R8: A read of register 4 returns system time bits 31:0 and latches bits 63:32. A read of register 5 returns the latched upper word. Read data appears on the cycle after the read strobe and holds until the next read.
- R9: Registers 0 to 3 read back the last value written to them.
- R10: After reset, the system time, the integer MAC time and the fractional MAC time are 0. The dividers hold their parameter defaults, and the read data is 0.
- R11: The integer MAC time output is a full 64-bit count, so an increment carries from bit 31 into bit 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Register-bus clock; clocks the system time |
| rst_bus_n | input | 1 | Asynchronous active-low reset, bus domain |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| clk_proc | input | 1 | Processing clock; clocks the MAC time |
| rst_proc_n | input | 1 | Asynchronous active-low reset, processing domain |
| mac_int_o | output | 64 | Live integer MAC time in microseconds |
| mac_frac_o | output | 16 | Live fractional MAC time in processing cycles |

## Verification
The MAC time is driven through a sequence of divider and load pairs. The sequence includes an ordinary divider, a divider of 1, a divider of 0, a jump backwards, and a load just below a 32-bit boundary. Each pair separates the fractional count, the wrap point and the carry into the upper word. The system time is sampled at read pairs spaced an exact multiple of the divider apart, so a wrong prescale shows up as a wrong difference. The same read pairs are repeated with writes to the time registers placed between them, and with a divider of 0.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
   localparam int REG_AW = 3;

   typedef enum logic [REG_AW-1:0] {
      RA_SYS_DIV = 3'd0,
      RA_MAC_DIV = 3'd1,
      RA_LD_LO   = 3'd2,
      RA_LD_HI   = 3'd3,
      RA_SYS_LO  = 3'd4,
      RA_SYS_HI  = 3'd5
   } reg_addr_e;
endpackage

// File: rtl/tbase_accum.sv
// Phase counter plus whole-unit counter with optional load.
module tbase_accum #(
   parameter int CNT_W = 64,
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] limit,
   input  logic             ld,
   input  logic [CNT_W-1:0] ld_val,
   output logic [DIV_W-1:0] phase,
   output logic [CNT_W-1:0] whole
);
   localparam logic [DIV_W-1:0] P_ONE = DIV_W'(1);
   localparam logic [CNT_W-1:0] W_ONE = CNT_W'(1);

   logic [DIV_W-1:0] eff_lim;
   logic             wrap;

   // a zero limit behaves as one so the phase never stalls
   assign eff_lim = (limit == '0) ? P_ONE : limit;
   assign wrap    = (phase >= (eff_lim - P_ONE));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= '0;
         whole <= '0;
      end else if (ld) begin
         phase <= '0;
         whole <= ld_val;
      end else if (wrap) begin
         phase <= '0;
         whole <= whole + W_ONE;
      end else begin
         phase <= phase + P_ONE;
      end
   end
endmodule

// File: rtl/tbase_xfer.sv
// Toggle-handshake transfer of a held word into another clock domain.
module tbase_xfer #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         src_clk,
   input  logic         src_rst_n,
   input  logic         src_req,
   input  logic [W-1:0] src_data,
   input  logic         dst_clk,
   input  logic         dst_rst_n,
   output logic         dst_pulse,
   output logic [W-1:0] dst_data
);
   logic              tog;
   logic [W-1:0]      hold;
   logic [STAGES-1:0] sh;
   logic              seen;

   always_ff @(posedge src_clk or negedge src_rst_n) begin
      if (!src_rst_n) begin
         tog  <= 1'b0;
         hold <= '0;
      end else if (src_req) begin
         tog  <= ~tog;
         hold <= src_data;
      end
   end

   always_ff @(posedge dst_clk or negedge dst_rst_n) begin
      if (!dst_rst_n) begin
         sh   <= '0;
         seen <= 1'b0;
      end else begin
         sh   <= {sh[STAGES-2:0], tog};
         seen <= sh[STAGES-1];
      end
   end

   // hold is stable for several destination cycles around the edge
   assign dst_pulse = sh[STAGES-1] ^ seen;
   assign dst_data  = hold;
endmodule

// File: rtl/tbase_top.sv
module tbase_top #(
   parameter int DATA_W      = 32,
   parameter int TIME_W      = 64,
   parameter int DIV_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter int SYS_DIV_DEF = 250,
   parameter int MAC_DIV_DEF = 160
) (
   input  logic                        clk_bus,
   input  logic                        rst_bus_n,
   input  logic                        reg_wr,
   input  logic                        reg_rd,
   input  logic [tbase_pkg::REG_AW-1:0] reg_addr,
   input  logic [DATA_W-1:0]           reg_wdata,
   output logic [DATA_W-1:0]           reg_rdata,
   input  logic                        clk_proc,
   input  logic                        rst_proc_n,
   output logic [TIME_W-1:0]           mac_int_o,
   output logic [DIV_W-1:0]            mac_frac_o
);
   import tbase_pkg::*;

   localparam int HI_W = TIME_W - DATA_W;
   localparam logic [DIV_W-1:0] SYS_DEF = DIV_W'(SYS_DIV_DEF);
   localparam logic [DIV_W-1:0] MAC_DEF = DIV_W'(MAC_DIV_DEF);

   generate
      if (TIME_W != 2 * DATA_W) begin : g_bad_time_w
         $error("tbase_top: TIME_W must be twice DATA_W");
      end
      if (DIV_W > DATA_W) begin : g_bad_div_w
         $error("tbase_top: DIV_W must not exceed DATA_W");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("tbase_top: SYNC_STAGES must be at least 2");
      end
   endgenerate

   // ---------------- bus domain ----------------
   logic [DIV_W-1:0]  sys_div;
   logic [DIV_W-1:0]  mac_div_b;
   logic [DATA_W-1:0] ld_lo;
   logic [DATA_W-1:0] ld_hi;
   logic [HI_W-1:0]   hi_latch;
   logic [TIME_W-1:0] sys_us;
   logic [DIV_W-1:0]  sys_phase;
   logic              div_req;
   logic              ld_req;
   reg_addr_e         addr_e;

   assign addr_e  = reg_addr_e'(reg_addr);
   assign div_req = reg_wr && (addr_e == RA_MAC_DIV);
   assign ld_req  = reg_wr && (addr_e == RA_LD_HI);

   always_ff @(posedge clk_bus or negedge rst_bus_n) begin
      if (!rst_bus_n) begin
         sys_div   <= SYS_DEF;
         mac_div_b <= MAC_DEF;
         ld_lo     <= '0;
         ld_hi     <= '0;
      end else if (reg_wr) begin
         case (addr_e)
            RA_SYS_DIV: sys_div   <= reg_wdata[DIV_W-1:0];
            RA_MAC_DIV: mac_div_b <= reg_wdata[DIV_W-1:0];
            RA_LD_LO:   ld_lo     <= reg_wdata;
            RA_LD_HI:   ld_hi     <= reg_wdata;
            default:    ;
         endcase
      end
   end

   always_ff @(posedge clk_bus or negedge rst_bus_n) begin
      if (!rst_bus_n) begin
         reg_rdata <= '0;
         hi_latch  <= '0;
      end else if (reg_rd) begin
         case (addr_e)
            RA_SYS_DIV: reg_rdata <= DATA_W'(sys_div);
            RA_MAC_DIV: reg_rdata <= DATA_W'(mac_div_b);
            RA_LD_LO:   reg_rdata <= ld_lo;
            RA_LD_HI:   reg_rdata <= ld_hi;
            RA_SYS_LO: begin
               reg_rdata <= sys_us[DATA_W-1:0];
               hi_latch  <= sys_us[TIME_W-1:DATA_W];
            end
            RA_SYS_HI:  reg_rdata <= DATA_W'(hi_latch);
            default:    reg_rdata <= '0;
         endcase
      end
   end

   tbase_accum #(.CNT_W(TIME_W), .DIV_W(DIV_W)) i_sys (
      .clk    (clk_bus),
      .rst_n  (rst_bus_n),
      .limit  (sys_div),
      .ld     (1'b0),
      .ld_val ({TIME_W{1'b0}}),
      .phase  (sys_phase),
      .whole  (sys_us)
   );

   // ---------------- crossings ----------------
   logic              div_pulse;
   logic [DIV_W-1:0]  div_x;
   logic              ld_pulse;
   logic [TIME_W-1:0] ld_x;

   tbase_xfer #(.W(DIV_W), .STAGES(SYNC_STAGES)) i_xdiv (
      .src_clk   (clk_bus),
      .src_rst_n (rst_bus_n),
      .src_req   (div_req),
      .src_data  (reg_wdata[DIV_W-1:0]),
      .dst_clk   (clk_proc),
      .dst_rst_n (rst_proc_n),
      .dst_pulse (div_pulse),
      .dst_data  (div_x)
   );

   tbase_xfer #(.W(TIME_W), .STAGES(SYNC_STAGES)) i_xld (
      .src_clk   (clk_bus),
      .src_rst_n (rst_bus_n),
      .src_req   (ld_req),
      .src_data  ({reg_wdata, ld_lo}),
      .dst_clk   (clk_proc),
      .dst_rst_n (rst_proc_n),
      .dst_pulse (ld_pulse),
      .dst_data  (ld_x)
   );

   // ---------------- processing domain ----------------
   logic [DIV_W-1:0] mac_div_p;

   always_ff @(posedge clk_proc or negedge rst_proc_n) begin
      if (!rst_proc_n)    mac_div_p <= MAC_DEF;
      else if (div_pulse) mac_div_p <= div_x;
   end

   tbase_accum #(.CNT_W(TIME_W), .DIV_W(DIV_W)) i_mac (
      .clk    (clk_proc),
      .rst_n  (rst_proc_n),
      .limit  (mac_div_p),
      .ld     (ld_pulse),
      .ld_val (ld_x),
      .phase  (mac_frac_o),
      .whole  (mac_int_o)
   );

   // phase of the system prescaler is internal only
   logic unused_phase;
   assign unused_phase = ^sys_phase;
endmodule

// File: rtl/tbase_chk.sv
module tbase_chk #(
   parameter int TIME_W = 64,
   parameter int DIV_W  = 16
) (
   input logic              clk_bus,
   input logic              rst_bus_n,
   input logic [TIME_W-1:0] sys_us,
   input logic              clk_proc,
   input logic              rst_proc_n,
   input logic [TIME_W-1:0] mac_int,
   input logic [DIV_W-1:0]  mac_frac,
   input logic              ld_evt,
   input logic [TIME_W-1:0] ld_val
);
   localparam logic [TIME_W-1:0] T1 = TIME_W'(1);
   localparam logic [DIV_W-1:0]  F1 = DIV_W'(1);

   // R1: system time holds or steps by one
   p_sys_step_r1: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
      (sys_us == $past(sys_us)) || (sys_us == $past(sys_us) + T1));

   // R3: a nonzero fraction came from an increment with the integer held
   p_frac_inc_r3: assert property (@(posedge clk_proc) disable iff (!rst_proc_n)
      ($past(!ld_evt) && mac_frac != '0) |->
         (mac_frac == $past(mac_frac) + F1) && (mac_int == $past(mac_int)));

   // R4: without a load, the integer only moves by one, on a wrap to zero
   p_int_wrap_r4: assert property (@(posedge clk_proc) disable iff (!rst_proc_n)
      ($past(!ld_evt) && mac_int != $past(mac_int)) |->
         (mac_int == $past(mac_int) + T1) && (mac_frac == '0));

   // R6: a load lands the staged value with a cleared fraction
   p_load_r6: assert property (@(posedge clk_proc) disable iff (!rst_proc_n)
      $past(ld_evt) |-> (mac_int == $past(ld_val)) && (mac_frac == '0));

   // R6: a load pulse lasts a single cycle
   p_load_once_r6: assert property (@(posedge clk_proc) disable iff (!rst_proc_n)
      ld_evt |=> !ld_evt);
endmodule

bind tbase_top tbase_chk #(.TIME_W(TIME_W), .DIV_W(DIV_W)) i_tbase_chk (
   .clk_bus    (clk_bus),
   .rst_bus_n  (rst_bus_n),
   .sys_us     (sys_us),
   .clk_proc   (clk_proc),
   .rst_proc_n (rst_proc_n),
   .mac_int    (mac_int_o),
   .mac_frac   (mac_frac_o),
   .ld_evt     (ld_pulse),
   .ld_val     (ld_x)
);

// File: tb/test_tbase_top.sv
module test_tbase_top;
   localparam int SYS_DEF = 250;
   localparam int MAC_DEF = 160;

   logic        clk_bus = 1'b0;
   logic        clk_proc = 1'b0;
   logic        rst_bus_n = 1'b0;
   logic        rst_proc_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [63:0] mac_int_o;
   logic [15:0] mac_frac_o;

   int n_run = 0;
   int n_fail = 0;

   always #2 clk_bus = ~clk_bus;   // 250 MHz
   always #3 clk_proc = ~clk_proc;

   tbase_top #(.SYS_DIV_DEF(SYS_DEF), .MAC_DIV_DEF(MAC_DEF)) i_tbase_top (
      .clk_bus    (clk_bus),
      .rst_bus_n  (rst_bus_n),
      .reg_wr     (reg_wr),
      .reg_rd     (reg_rd),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .clk_proc   (clk_proc),
      .rst_proc_n (rst_proc_n),
      .mac_int_o  (mac_int_o),
      .mac_frac_o (mac_frac_o)
   );

   // vector table: MAC divider, load upper word, load lower word
   localparam int NV = 5;
   localparam logic [31:0] V_DIV [NV] = '{32'd4, 32'd1, 32'd0, 32'd3, 32'd7};
   localparam logic [31:0] V_HI  [NV] = '{32'd0, 32'd0, 32'd0, 32'd1, 32'd0};
   localparam logic [31:0] V_LO  [NV] = '{32'd1000, 32'd40, 32'd9000,
                                          32'hFFFF_FFFF, 32'd12};

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // bus tasks start and end at a bus negedge
   task automatic bw(input logic [2:0] a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk_bus);
      reg_wr = 1'b0;
   endtask

   task automatic br(input logic [2:0] a, output logic [31:0] d);
      reg_rd = 1'b1; reg_addr = a;
      @(negedge clk_bus);
      reg_rd = 1'b0;
      d = reg_rdata;
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
   endtask

   initial begin
      repeat (200000) @(posedge clk_bus);
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] a, b;
      logic [63:0] v;
      int lim;
      bit found;

      repeat (5) @(negedge clk_bus);
      // R10: state under reset
      chk("R10 mac_int reset", mac_int_o, 64'd0);
      chk("R10 mac_frac reset", 64'(mac_frac_o), 64'd0);
      chk("R10 rdata reset", 64'(reg_rdata), 64'd0);
      rst_bus_n = 1'b1;
      rst_proc_n = 1'b1;
      @(negedge clk_bus);

      br(3'd0, a); chk("R10 sys divider default", 64'(a), 64'(SYS_DEF));
      br(3'd1, a); chk("R10 mac divider default", 64'(a), 64'(MAC_DEF));
      br(3'd5, a); chk("R10 sys high zero", 64'(a), 64'd0);

      // R2: default divider, reads spaced 2*SYS_DEF apart
      br(3'd4, a);
      repeat (2 * SYS_DEF - 1) @(negedge clk_bus);
      br(3'd4, b);
      chk("R2 default prescale", 64'(b - a), 64'd2);

      // R2 and R9: programmed divider
      bw(3'd0, 32'd5);
      br(3'd0, a); chk("R9 sys divider readback", 64'(a), 64'd5);
      repeat (10) @(negedge clk_bus);
      br(3'd4, a);
      repeat (14) @(negedge clk_bus);
      br(3'd4, b);
      chk("R2 divider 5", 64'(b - a), 64'd3);

      // R7: writes to time registers in the gap change nothing
      br(3'd4, a);
      bw(3'd4, 32'h0);
      bw(3'd5, 32'hFFFF);
      repeat (12) @(negedge clk_bus);
      br(3'd4, b);
      chk("R7 sys time unaffected by writes", 64'(b - a), 64'd3);
      br(3'd5, b);
      chk("R8 latched upper word", 64'(b), 64'd0);
      chk("R8 rdata holds", 64'(reg_rdata), 64'd0);

      // R2: divider 0 acts as 1
      bw(3'd0, 32'd0);
      repeat (4) @(negedge clk_bus);
      br(3'd4, a);
      repeat (9) @(negedge clk_bus);
      br(3'd4, b);
      chk("R2 divider 0", 64'(b - a), 64'd10);

      // vector walk over MAC time: R3 R4 R5 R6 R11
      for (int i = 0; i < NV; i++) begin
         bw(3'd1, V_DIV[i]);
         bw(3'd2, V_LO[i]);
         bw(3'd3, V_HI[i]);
         v = {V_HI[i], V_LO[i]};
         lim = (V_DIV[i] == 0) ? 1 : int'(V_DIV[i]);
         found = 1'b0;
         for (int k = 0; k < 40; k++) begin
            @(negedge clk_proc);
            if (mac_int_o == v) begin
               found = 1'b1;
               break;
            end
         end
         chk("R6 load lands", 64'(found), 64'd1);
         chk("R6 load clears fraction", 64'(mac_frac_o), 64'd0);
         if (lim > 1) begin
            repeat (lim - 1) @(negedge clk_proc);
            chk("R3 fraction at limit-1", 64'(mac_frac_o), 64'(lim - 1));
            chk("R3 integer held", mac_int_o, v);
            @(negedge clk_proc);
         end else begin
            @(negedge clk_proc);
            chk("R5 fraction stays zero", 64'(mac_frac_o), 64'd0);
         end
         chk("R4 integer after wrap", mac_int_o, v + 64'd1);
         chk("R4 fraction after wrap", 64'(mac_frac_o), 64'd0);
         if (i == 3) chk("R11 carry into upper word", mac_int_o, 64'h2_0000_0000);
         @(negedge clk_bus);
      end

      // R9: configuration readback
      br(3'd1, a); chk("R9 mac divider readback", 64'(a), 64'd7);
      br(3'd2, a); chk("R9 load low readback", 64'(a), 64'd12);
      br(3'd3, a); chk("R9 load high readback", 64'(a), 64'd0);

      // R1: system time kept counting through all of the above
      br(3'd4, a);
      repeat (3) @(negedge clk_bus);
      br(3'd4, b);
      chk("R1 system time monotonic", 64'(b - a), 64'd4);

      summary();
      $finish;
   end
endmodule